// File: doc/BRIEF.md
# Read-Address Sequence Unlock Detector

This block watches the address side of an asynchronous SRAM port and recognises a hidden command made only of ordinary reads. One sample is taken for each completed access cycle, marked by a one-clock `cycleDone` strobe. Five fixed read addresses must arrive back to back: 0x0000, 0x1555, 0x0AAA, 0x1FFF, 0x10F0. A sixth read then chooses the command. 0x0F0F asks for a nonvolatile store and 0x0F0E asks for a nonvolatile recall.

The detector only observes the port. It never stalls or redirects the read data path, so every read in the key still returns array data as normal. When the key completes, the block raises a one-clock request toward the nonvolatile engine and goes back to idle. Any write cycle inside the key cancels it. A counted read at an unexpected address also cancels the key, but if that address is 0x0000 it starts a fresh key. Cycles with the chip deselected do not count, and output enable plays no part in recognition.

Top module: `seqUnlock`

## Requirements
- R1: After reset the matcher is idle (no key progress) and both `storeReq` and `recallReq` are low.
- R2: A counted read sequence 0x0000, 0x1555, 0x0AAA, 0x1FFF, 0x10F0, 0x0F0F pulses `storeReq`. The pulse is high in the clock after the edge that samples the sixth `cycleDone`. `recallReq` stays low.
- R3: The same five-read prefix followed by 0x0F0E pulses `recallReq` in the same cycle position, and `storeReq` stays low.
- R4: A counted read at an address other than the expected one, including a sixth address that is neither final key, gives no request. It returns the matcher to step 0, or to step 1 when that address is 0x0000.
- R5: A counted cycle with `weN` low at any point in the key gives no request and returns the matcher to step 0.
- R6: Cycles with `ceN` high are ignored. Inserted between key steps, they neither break nor advance the key.
- R7: The level of `oeN` has no effect on recognition. A key entered with `oeN` high or low gives the same request.
- R8: A request lasts exactly one clock, the two requests are never high together, and after a request the full six-read key is needed again.
- R9: Address and enable values are sampled only on clocks where `cycleDone` is high. Other clocks have no effect on the key.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low synchronous reset |
| ceN | input | 1 | Chip enable of the watched port, active low |
| weN | input | 1 | Write enable of the watched port, active low |
| oeN | input | 1 | Output enable of the watched port, active low (not used for recognition) |
| addr | input | 13 | Address of the watched port |
| cycleDone | input | 1 | One-clock strobe marking a completed access cycle |
| storeReq | output | 1 | One-clock nonvolatile store request |
| recallReq | output | 1 | One-clock nonvolatile recall request |

## Verification
The bench builds the block with its default parameters: a 13-bit address and the standard key values. This puts every step of the six-step key within reach of a full sweep. For each break position, the bench tries a foreign address, a write, a restart at 0x0000 and an inserted deselected cycle. Each attempt is then followed by a clean key, which shows the matcher state through the next request. Both final addresses are entered under both `oeN` levels, and idle clocks with changing addresses lie between strobes.

// File: rtl/seqUnlockPkg.sv
package seqUnlockPkg;
  // strobes from the address datapath to the step controller
  typedef struct packed {
    logic counted;   // completed cycle with chip selected
    logic isWrite;   // that cycle was a write
    logic hitNext;   // address equals the expected prefix entry for the current step
    logic isHead;    // address equals the first key entry
    logic isStore;   // address equals the store final key
    logic isRecall;  // address equals the recall final key
  } keyStrobes_t;
endpackage

// File: rtl/seqUnlockDatapath.sv
module seqUnlockDatapath
  import seqUnlockPkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int PREFIX_LEN = 5,
  parameter int STEP_W = 3,
  parameter logic [ADDR_W-1:0] KEY0 = 13'h0000,
  parameter logic [ADDR_W-1:0] KEY1 = 13'h1555,
  parameter logic [ADDR_W-1:0] KEY2 = 13'h0AAA,
  parameter logic [ADDR_W-1:0] KEY3 = 13'h1FFF,
  parameter logic [ADDR_W-1:0] KEY4 = 13'h10F0,
  parameter logic [ADDR_W-1:0] STORE_KEY = 13'h0F0F,
  parameter logic [ADDR_W-1:0] RECALL_KEY = 13'h0F0E
) (
  input  logic              ceN,
  input  logic              weN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              cycleDone,
  input  logic [STEP_W-1:0] step,
  output keyStrobes_t       strobes
);
  localparam logic [ADDR_W-1:0] KEY_TAB [PREFIX_LEN] = '{KEY0, KEY1, KEY2, KEY3, KEY4};

  logic [PREFIX_LEN-1:0] keyHit;

  for (genvar i = 0; i < PREFIX_LEN; i++) begin : g_cmp
    assign keyHit[i] = (addr == KEY_TAB[i]);
  end

  always_comb begin
    strobes.counted  = cycleDone && !ceN;
    strobes.isWrite  = !weN;
    strobes.hitNext  = (step < STEP_W'(PREFIX_LEN)) ? keyHit[step] : 1'b0;
    strobes.isHead   = keyHit[0];
    strobes.isStore  = (addr == STORE_KEY);
    strobes.isRecall = (addr == RECALL_KEY);
  end
endmodule

// File: rtl/seqUnlockControl.sv
module seqUnlockControl
  import seqUnlockPkg::*;
#(
  parameter int PREFIX_LEN = 5,
  parameter int STEP_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              oeN,
  input  keyStrobes_t       strobes,
  output logic [STEP_W-1:0] step,
  output logic              storeReq,
  output logic              recallReq
);
  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(PREFIX_LEN);

  logic [STEP_W-1:0] stepNext;
  logic storeNext, recallNext;

  always_comb begin
    stepNext   = step;
    storeNext  = 1'b0;
    recallNext = 1'b0;
    if (strobes.counted) begin
      if (strobes.isWrite) begin
        stepNext = '0;
      end else if (step == LAST_STEP) begin
        if (strobes.isStore) begin
          storeNext = 1'b1;
          stepNext  = '0;
        end else if (strobes.isRecall) begin
          recallNext = 1'b1;
          stepNext   = '0;
        end else begin
          stepNext = strobes.isHead ? STEP_W'(1) : '0;
        end
      end else if (strobes.hitNext) begin
        stepNext = step + STEP_W'(1);
      end else begin
        stepNext = strobes.isHead ? STEP_W'(1) : '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      step      <= '0;
      storeReq  <= 1'b0;
      recallReq <= 1'b0;
    end else begin
      step      <= stepNext;
      storeReq  <= storeNext;
      recallReq <= recallNext;
    end
  end

  // R8
  req_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(storeReq && recallReq));
  // R8
  store_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    storeReq |=> !storeReq && step == '0);
  // R8
  recall_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    recallReq |=> !recallReq && step == '0);
  // R5
  write_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.counted && strobes.isWrite) |=> (step == '0 && !storeReq && !recallReq));
  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.counted |=> ($stable(step) && !storeReq && !recallReq));
  // R7
  advance_oe_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.counted && !strobes.isWrite && strobes.hitNext && !oeN)
      |=> step == $past(step) + STEP_W'(1));
  // R7
  advance_oe_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.counted && !strobes.isWrite && strobes.hitNext && oeN)
      |=> step == $past(step) + STEP_W'(1));
  // R4
  step_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    step <= LAST_STEP);
endmodule

// File: rtl/seqUnlock.sv
module seqUnlock
  import seqUnlockPkg::*;
#(
  parameter int ADDR_W = 13,
  parameter logic [ADDR_W-1:0] KEY0 = 13'h0000,
  parameter logic [ADDR_W-1:0] KEY1 = 13'h1555,
  parameter logic [ADDR_W-1:0] KEY2 = 13'h0AAA,
  parameter logic [ADDR_W-1:0] KEY3 = 13'h1FFF,
  parameter logic [ADDR_W-1:0] KEY4 = 13'h10F0,
  parameter logic [ADDR_W-1:0] STORE_KEY = 13'h0F0F,
  parameter logic [ADDR_W-1:0] RECALL_KEY = 13'h0F0E
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ceN,
  input  logic              weN,
  input  logic              oeN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              cycleDone,
  output logic              storeReq,
  output logic              recallReq
);
  localparam int PREFIX_LEN = 5;
  localparam int STEP_W = $clog2(PREFIX_LEN + 1);

  keyStrobes_t strobes;
  logic [STEP_W-1:0] step;

  seqUnlockDatapath #(
    .ADDR_W(ADDR_W), .PREFIX_LEN(PREFIX_LEN), .STEP_W(STEP_W),
    .KEY0(KEY0), .KEY1(KEY1), .KEY2(KEY2), .KEY3(KEY3), .KEY4(KEY4),
    .STORE_KEY(STORE_KEY), .RECALL_KEY(RECALL_KEY)
  ) u_dp (
    .ceN(ceN), .weN(weN), .addr(addr), .cycleDone(cycleDone),
    .step(step), .strobes(strobes)
  );

  seqUnlockControl #(.PREFIX_LEN(PREFIX_LEN), .STEP_W(STEP_W)) u_ctl (
    .clk(clk), .rstN(rstN), .oeN(oeN), .strobes(strobes),
    .step(step), .storeReq(storeReq), .recallReq(recallReq)
  );
endmodule

// File: tb/sim_seqUnlock.sv
module sim_seqUnlock;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ceN = 1'b1, weN = 1'b1, oeN = 1'b1, cycleDone = 1'b0;
  logic [12:0] addr = '0;
  logic storeReq, recallReq;
  int checks = 0;
  int errors = 0;
  int stores = 0;
  int recalls = 0;
  logic lastS, lastR;

  always #2.5 clk = ~clk;

  seqUnlock u0 (
    .clk(clk), .rstN(rstN), .ceN(ceN), .weN(weN), .oeN(oeN), .addr(addr),
    .cycleDone(cycleDone), .storeReq(storeReq), .recallReq(recallReq)
  );

  function automatic logic [12:0] keyAt(int i);
    case (i)
      0: return 13'h0000;
      1: return 13'h1555;
      2: return 13'h0AAA;
      3: return 13'h1FFF;
      default: return 13'h10F0;
    endcase
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // one completed cycle, then sample the request outputs; R8 single-clock check
  task automatic access(logic c, logic w, logic o, logic [12:0] a);
    @(negedge clk);
    ceN = c; weN = w; oeN = o; addr = a; cycleDone = 1'b1;
    @(negedge clk);
    cycleDone = 1'b0;
    addr = ~a;  // R9: address moves on a clock without a strobe
    lastS = storeReq; lastR = recallReq;
    if (storeReq) stores++;
    if (recallReq) recalls++;
    @(negedge clk);
    check(!storeReq && !recallReq, "R8 single clock", int'(storeReq) + int'(recallReq), 0);
  endtask

  task automatic prefix(int from, int upto, logic o);
    for (int i = from; i < upto; i++) access(1'b0, 1'b1, o, keyAt(i));
  endtask

  // full key; expect a request of the given kind (1 store, 2 recall)
  task automatic fullKey(int kind, logic o, string req);
    prefix(0, 5, o);
    access(1'b0, 1'b1, o, (kind == 1) ? 13'h0F0F : 13'h0F0E);
    check(lastS == (kind == 1) && lastR == (kind == 2), req,
          int'(lastS) * 2 + int'(lastR), (kind == 1) ? 2 : 1);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual 1 expected 0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    check(!storeReq && !recallReq, "R1 reset", int'(storeReq) + int'(recallReq), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(!storeReq && !recallReq, "R1 after release", int'(storeReq) + int'(recallReq), 0);
    // R1: first read after reset is 0x1555 -> must not be mid-key
    access(1'b0, 1'b1, 1'b1, 13'h1555);
    prefix(2, 5, 1'b1);
    access(1'b0, 1'b1, 1'b1, 13'h0F0F);
    check(!lastS && !lastR, "R1 idle start", int'(lastS), 0);

    for (int o = 0; o < 2; o++) begin
      fullKey(1, o[0], "R2 store key");
      fullKey(2, o[0], "R3 recall key");
      fullKey(1, o[0], "R7 oe level");
    end

    for (int k = 0; k <= 5; k++) begin
      // R4: foreign address at step k
      stores = 0; recalls = 0;
      prefix(0, k, 1'b0);
      access(1'b0, 1'b1, 1'b0, 13'h1234);
      if (k < 5) begin
        prefix(k + 1, 5, 1'b0);
        access(1'b0, 1'b1, 1'b0, 13'h0F0F);
      end
      check(stores == 0 && recalls == 0, "R4 broken key", stores + recalls, 0);
      fullKey(2, 1'b0, "R4 recovery");

      // R5: write at step k, using a key address
      stores = 0; recalls = 0;
      prefix(0, k, 1'b1);
      access(1'b0, 1'b0, 1'b1, (k < 5) ? keyAt(k) : 13'h0F0F);
      if (k < 5) begin
        prefix(k + 1, 5, 1'b1);
        access(1'b0, 1'b1, 1'b1, 13'h0F0F);
      end
      check(stores == 0 && recalls == 0, "R5 write cancels", stores + recalls, 0);

      // R4: 0x0000 at step k>=1 restarts at step 1
      if (k >= 1) begin
        prefix(0, k, 1'b1);
        prefix(0, 5, 1'b1);
        access(1'b0, 1'b1, 1'b1, 13'h0F0E);
        check(lastR && !lastS, "R4 restart on head", int'(lastR), 1);
      end

      // R6: deselected cycle at step k does not break the key
      prefix(0, k, 1'b0);
      access(1'b1, 1'b0, 1'b0, 13'h0BAD);
      prefix(k, 5, 1'b0);
      access(1'b0, 1'b1, 1'b0, 13'h0F0F);
      check(lastS && !lastR, "R6 deselected ignored", int'(lastS), 1);
    end

    // R8: after a request the prefix alone does not fire again
    fullKey(1, 1'b1, "R8 first");
    stores = 0; recalls = 0;
    access(1'b0, 1'b1, 1'b1, 13'h0F0F);
    check(stores == 0, "R8 needs full key", stores, 0);

    // R9: idle clocks with key addresses but no strobe
    prefix(0, 3, 1'b1);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      ceN = 1'b0; weN = 1'b0; addr = 13'h1FFF;
    end
    prefix(3, 5, 1'b1);
    access(1'b0, 1'b1, 1'b1, 13'h0F0E);
    check(lastR && !lastS, "R9 strobe only", int'(lastR), 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule